// File: doc/BRIEF.md
# Dual-Source Memory Combine Engine

This block is a memory co-processor that walks two operand streams, A and B, through a shared memory. It merges them one element at a time with a chosen arithmetic or logic function and stores each result into a third, destination stream. The same engine can copy bitmaps, blend images, mix or scale audio samples, or run simple vector arithmetic, without a host processor touching each element.

Each stream has its own element width, byte start address and signed byte step. A length register sets the number of elements to process. The caller loads the configuration inputs and pulses `start`. The engine then holds `busy` high and pulses `done` once when it finishes. If the caller selects a function or width that the engine does not support, it raises `err` and does not start.

Memory is reached through one 128-bit word port. A request is held until it is granted. Read data comes back later, marked by `mem_rvalid`. Writes carry byte enables, so only the destination element's bytes change.

Top module: `mem_combine_engine`

## Requirements
- R1: During and after reset, `busy`, `done`, `err` and `mem_req` are all low.
- R2: A run with length N performs exactly N destination writes. `busy` is high from the cycle after `start` is accepted. `done` is high for one cycle, in the cycle after the last write is granted, and `busy` is low in that same cycle.
- R3: Width code w (0 to 4) selects an element of 2^w bytes (8 to 128 bits). The element address is aligned down to a multiple of its size, and the element sits little-endian in the memory word: byte k of word W is byte address 16·W+k, carried on data bits 8k+7..8k.
- R4: After each element, every stream address advances by its own signed step, taken as a two's-complement byte count. A negative step walks downward.
- R5: Source elements are zero-extended to 128 bits. The result is cut to the destination width, so arithmetic wraps modulo 2^(8·2^wd). Write byte enables cover only the destination element's bytes.
- R6: Function code 0 passes A, 1 passes B, 2 gives A+B, 3 gives A−B, 4 gives A×B, 5 gives A XOR B, 6 gives A AND B and 7 gives A OR B.
- R7: The input mask is ANDed with both operands before the function is applied. The output mask is ANDed with the result before it is written.
- R8: A start with function code 8 or above, or with any width code above 4, sets `err`. In that case `busy` stays low, `done` does not pulse and no memory access takes place. The next valid start clears `err`.
- R9: A `start` pulse while `busy` is high is ignored. The configuration is captured when a run is accepted, so changes to it during the run have no effect.
- R10: A start with length 0 pulses `done` in the next cycle, never raises `busy` and makes no memory access.
- R11: A request is held with a stable address and direction until `mem_gnt`. Grant stalls change only the timing of a run, never its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| cfg_len | input | LW | Number of elements |
| cfg_a_wid | input | 3 | Source A width code |
| cfg_a_addr | input | AW | Source A start byte address |
| cfg_a_step | input | AW | Source A signed byte step |
| cfg_b_wid | input | 3 | Source B width code |
| cfg_b_addr | input | AW | Source B start byte address |
| cfg_b_step | input | AW | Source B signed byte step |
| cfg_d_wid | input | 3 | Destination width code |
| cfg_d_addr | input | AW | Destination start byte address |
| cfg_d_step | input | AW | Destination signed byte step |
| cfg_func | input | 4 | Combine function code |
| cfg_mask_in | input | DW | Operand mask |
| cfg_mask_out | input | DW | Result mask |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported configuration seen at the last start |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW-4 | Word address |
| mem_wdata | output | DW | Write data |
| mem_be | output | DW/8 | Write byte enables |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |

## Verification
The bench aims at the places where element handling goes wrong:
- **Unaligned start addresses.** A design that skipped the align-down would shift every element.
- **Negative steps.** A step treated as unsigned would jump far upward instead of walking down.
- **Destinations narrower than the result.** A design that failed to cut the result would write into neighbouring bytes.
- **Destinations wider than the sources.** A design that failed to zero-extend would write stale upper bytes.

It also covers the control corner cases:
- a zero length, which must end at once;
- rejected function and width codes, which must leave memory untouched;
- a second start during a run, which must not restart or reconfigure the engine;
- grant stalls, which a design that dropped a held request would turn into lost or repeated elements.

// File: rtl/mem_combine_engine.sv
module mem_combine_engine #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 128,
  localparam int BW = DW / 8,
  localparam int OW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] cfg_len,
  input  logic [2:0]    cfg_a_wid,
  input  logic [AW-1:0] cfg_a_addr,
  input  logic [AW-1:0] cfg_a_step,
  input  logic [2:0]    cfg_b_wid,
  input  logic [AW-1:0] cfg_b_addr,
  input  logic [AW-1:0] cfg_b_step,
  input  logic [2:0]    cfg_d_wid,
  input  logic [AW-1:0] cfg_d_addr,
  input  logic [AW-1:0] cfg_d_step,
  input  logic [3:0]    cfg_func,
  input  logic [DW-1:0] cfg_mask_in,
  input  logic [DW-1:0] cfg_mask_out,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-OW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [BW-1:0] mem_be,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);

  typedef enum logic [2:0] {IDLE, RD_A, WT_A, RD_B, WT_B, WR_D} st_t;

  st_t           st;
  logic [AW-1:0] pa, pb, pd, sa, sb, sd, cur;
  logic [2:0]    wa, wb, wd;
  logic [3:0]    fn;
  logic [DW-1:0] mi, mo, va, vb, raw, res;
  logic [LW-1:0] left;
  logic [OW-1:0] d_off;
  logic          done_q, err_q, cfg_bad;

  function automatic logic [OW-1:0] lane(input logic [OW-1:0] lo, input logic [2:0] w);
    return lo & ~OW'((1 << w) - 1);
  endfunction

  function automatic logic [DW-1:0] keep(input logic [2:0] w);
    return (DW'(1) << (8 << w)) - DW'(1);
  endfunction

  function automatic logic [DW-1:0] pick(input logic [AW-1:0] ad, input logic [2:0] w,
                                         input logic [DW-1:0] word, input logic [DW-1:0] m);
    return (word >> {lane(ad[OW-1:0], w), 3'b000}) & keep(w) & m;
  endfunction

  assign cfg_bad = (cfg_func > 4'd7) || (cfg_a_wid > 3'(OW)) ||
                   (cfg_b_wid > 3'(OW)) || (cfg_d_wid > 3'(OW));

  assign busy    = (st != IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign mem_req = (st == RD_A) || (st == RD_B) || (st == WR_D);
  assign mem_we  = (st == WR_D);
  assign cur     = (st == WR_D) ? pd : ((st == RD_B) || (st == WT_B)) ? pb : pa;
  assign mem_addr = cur[AW-1:OW];

  always_comb begin
    case (fn)
      4'd0:    raw = va;
      4'd1:    raw = vb;
      4'd2:    raw = va + vb;
      4'd3:    raw = va - vb;
      4'd4:    raw = va * vb;
      4'd5:    raw = va ^ vb;
      4'd6:    raw = va & vb;
      default: raw = va | vb;
    endcase
  end

  assign res       = raw & mo & keep(wd);
  assign d_off     = lane(pd[OW-1:0], wd);
  assign mem_wdata = res << {d_off, 3'b000};
  assign mem_be    = BW'((64'd1 << (1 << wd)) - 64'd1) << d_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      done_q <= 1'b0;
      err_q <= 1'b0;
      pa <= '0; pb <= '0; pd <= '0;
      sa <= '0; sb <= '0; sd <= '0;
      wa <= '0; wb <= '0; wd <= '0;
      fn <= '0; mi <= '0; mo <= '0;
      va <= '0; vb <= '0; left <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: if (start) begin
          if (cfg_bad) err_q <= 1'b1;
          else begin
            err_q <= 1'b0;
            pa <= cfg_a_addr; sa <= cfg_a_step; wa <= cfg_a_wid;
            pb <= cfg_b_addr; sb <= cfg_b_step; wb <= cfg_b_wid;
            pd <= cfg_d_addr; sd <= cfg_d_step; wd <= cfg_d_wid;
            fn <= cfg_func; mi <= cfg_mask_in; mo <= cfg_mask_out;
            left <= cfg_len;
            if (cfg_len == '0) done_q <= 1'b1;
            else st <= RD_A;
          end
        end
        RD_A: if (mem_gnt) st <= WT_A;
        WT_A: if (mem_rvalid) begin
          va <= pick(pa, wa, mem_rdata, mi);
          st <= RD_B;
        end
        RD_B: if (mem_gnt) st <= WT_B;
        WT_B: if (mem_rvalid) begin
          vb <= pick(pb, wb, mem_rdata, mi);
          st <= WR_D;
        end
        WR_D: if (mem_gnt) begin
          pa <= pa + sa;
          pb <= pb + sb;
          pd <= pd + sd;
          left <= left - LW'(1);
          if (left == LW'(1)) begin
            st <= IDLE;
            done_q <= 1'b1;
          end else st <= RD_A;
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mem_combine_engine_checker.sv
module mem_combine_engine_checker #(
  parameter int WAW = 28,
  parameter int BW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic           mem_req,
  input logic           mem_we,
  input logic           mem_gnt,
  input logic [WAW-1:0] mem_addr,
  input logic [BW-1:0]  mem_be
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req); // R2

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(busy) |-> $past(mem_req && mem_we && mem_gnt)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R10

  AST_BE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> $onehot($countones(mem_be))); // R5

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy); // R8

endmodule

bind mem_combine_engine mem_combine_engine_checker #(.WAW(AW - OW), .BW(BW)) i_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_be(mem_be)
);

// File: tb/test_mem_combine_engine.sv
`timescale 1ns/1ps
module test_mem_combine_engine;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, start;
  logic [15:0]   cfg_len;
  logic [2:0]    cfg_a_wid, cfg_b_wid, cfg_d_wid;
  logic [31:0]   cfg_a_addr, cfg_a_step, cfg_b_addr, cfg_b_step, cfg_d_addr, cfg_d_step;
  logic [3:0]    cfg_func;
  logic [127:0]  cfg_mask_in, cfg_mask_out;
  logic          busy, done, err, mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [27:0]   mem_addr;
  logic [127:0]  mem_wdata, mem_rdata;
  logic [15:0]   mem_be;

  mem_combine_engine i_mem_combine_engine (.*);

  logic [127:0] mem [64];
  logic [7:0]   sh [1024];
  logic [7:0]   lfsr = 8'h5A;
  logic         stall_en = 1'b0;
  int wcnt = 0, rcnt = 0, w_base = 0, r_base = 0;
  int total = 0, bad = 0, cyc = 0;

  assign mem_gnt = mem_req && !(stall_en && lfsr[0]);

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        wcnt <= wcnt + 1;
        for (int k = 0; k < 16; k++)
          if (mem_be[k]) mem[mem_addr[5:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
      end else begin
        rcnt <= rcnt + 1;
        mem_rvalid <= 1'b1;
        mem_rdata <= mem[mem_addr[5:0]];
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] rd_el(input int ad, input int w);
    logic [127:0] v = '0;
    int nb = 1 << w;
    int base = ad & ~(nb - 1);
    for (int k = 0; k < nb; k++) v[8*k +: 8] = sh[(base + k) & 1023];
    return v;
  endfunction

  task automatic wr_el(input int ad, input int w, input logic [127:0] v);
    int nb = 1 << w;
    int base = ad & ~(nb - 1);
    for (int k = 0; k < nb; k++) sh[(base + k) & 1023] = v[8*k +: 8];
  endtask

  function automatic int diff();
    int n = 0;
    for (int w = 0; w < 64; w++)
      for (int k = 0; k < 16; k++)
        if (mem[w][8*k +: 8] !== sh[w*16 + k]) n++;
    return n;
  endfunction

  task automatic setcfg(input int n, input int aw, input int aa, input int as_,
                        input int bw, input int ba, input int bs,
                        input int dw, input int da, input int ds, input int f,
                        input logic [127:0] mi, input logic [127:0] mo);
    cfg_len = 16'(n);
    cfg_a_wid = 3'(aw); cfg_a_addr = 32'(aa); cfg_a_step = 32'(as_);
    cfg_b_wid = 3'(bw); cfg_b_addr = 32'(ba); cfg_b_step = 32'(bs);
    cfg_d_wid = 3'(dw); cfg_d_addr = 32'(da); cfg_d_step = 32'(ds);
    cfg_func = 4'(f); cfg_mask_in = mi; cfg_mask_out = mo;
  endtask

  task automatic apply_ref();
    int pa = int'(cfg_a_addr), pb = int'(cfg_b_addr), pd = int'(cfg_d_addr);
    logic [127:0] a, b, r;
    for (int e = 0; e < int'(cfg_len); e++) begin
      a = rd_el(pa, cfg_a_wid) & cfg_mask_in;
      b = rd_el(pb, cfg_b_wid) & cfg_mask_in;
      case (cfg_func)
        4'd0: r = a;
        4'd1: r = b;
        4'd2: r = a + b;
        4'd3: r = a - b;
        4'd4: r = a * b;
        4'd5: r = a ^ b;
        4'd6: r = a & b;
        default: r = a | b;
      endcase
      wr_el(pd, cfg_d_wid, r & cfg_mask_out);
      pa += int'(cfg_a_step); pb += int'(cfg_b_step); pd += int'(cfg_d_step);
    end
  endtask

  task automatic launch();
    @(negedge clk);
    start = 1'b1;
    w_base = wcnt; r_base = rcnt;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish(input string req, input int n);
    int t = 0;
    chk(busy == (n != 0), "R2", "busy after start", busy, n != 0);
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done, "R2", "done seen", done, 1);
    @(negedge clk);
    chk(!done && !busy, "R2", "done one cycle then idle", {done, busy}, 0);
    chk(wcnt - w_base == n, req, "write count", wcnt - w_base, n);
    chk(diff() == 0, req, "memory image mismatched bytes", diff(), 0);
  endtask

  task automatic run(input string req);
    int n = int'(cfg_len);
    apply_ref();
    launch();
    finish(req, n);
  endtask

  localparam logic [127:0] ONES = '1;

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0;
    setcfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, ONES, ONES);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !mem_req, "R1", "outputs in reset", {busy, done, err, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !mem_req, "R1", "outputs after reset", {busy, done, err, mem_req}, 0);
  endtask

  task automatic t_plain_copy();
    setcfg(6, 0, 'h10, 1, 0, 0, 0, 0, 'h200, 1, 0, ONES, ONES);
    run("R6");
  endtask

  task automatic t_wide_words();
    setcfg(3, 4, 'h40, 16, 4, 'h80, 16, 4, 'h220, 16, 2, ONES, ONES);
    run("R3");
  endtask

  task automatic t_reverse();
    setcfg(7, 1, 'h3F0, -2, 2, 'h40, 4, 1, 'h300, 2, 3, ONES, ONES);
    run("R4");
  endtask

  task automatic t_funcs();
    for (int f = 0; f < 8; f++) begin
      setcfg(3, 2, 'h20 + f, 4, 2, 'h60, 12, 3, 'h280 + 32*f, 8, f, ONES, ONES);
      run("R6");
    end
  endtask

  task automatic t_mul_trunc();
    setcfg(5, 3, 'h90, 8, 3, 'hC8, -8, 0, 'h37F, -1, 4, ONES, ONES);
    run("R5");
  endtask

  task automatic t_mask();
    setcfg(4, 2, 'h10, 4, 2, 'h50, 4, 2, 'h380, 4, 7,
           {32{4'hF}} & 128'h0F0F0F0F_0F0F0F0F_0F0F0F0F_0F0F0F0F,
           128'h00FF00FF_00FF00FF_00FF00FF_00FF00FF);
    run("R7");
  endtask

  task automatic t_unaligned();
    setcfg(4, 2, 'h23, 4, 0, 'h71, 3, 1, 'h105, 6, 2, ONES, ONES);
    run("R3");
  endtask

  task automatic t_len0();
    setcfg(0, 0, 0, 1, 0, 0, 1, 0, 'h100, 1, 0, ONES, ONES);
    apply_ref();
    launch();
    chk(done && !busy, "R10", "done at once", {done, busy}, 2'b10);
    @(negedge clk);
    chk(!done, "R10", "done single", done, 0);
    chk(wcnt == w_base && rcnt == r_base, "R10", "no accesses", (wcnt - w_base) + (rcnt - r_base), 0);
    chk(diff() == 0, "R10", "memory untouched", diff(), 0);
  endtask

  task automatic t_error();
    int dn;
    int codes[3] = '{8, 12, 0};
    for (int i = 0; i < 3; i++) begin
      setcfg(4, (i == 2) ? 5 : 0, 0, 1, 0, 0, 1, 0, 'h3C0, 1, codes[i], ONES, ONES);
      launch();
      chk(err && !busy, "R8", "err raised, idle", {err, busy}, 2'b10);
      dn = 0;
      repeat (8) begin @(negedge clk); if (done || busy) dn++; end
      chk(dn == 0, "R8", "no done or busy", dn, 0);
      chk(wcnt == w_base && rcnt == r_base, "R8", "no accesses", (wcnt - w_base) + (rcnt - r_base), 0);
      chk(diff() == 0, "R8", "memory untouched", diff(), 0);
    end
    setcfg(2, 0, 0, 1, 0, 0, 1, 0, 'h3C0, 1, 0, ONES, ONES);
    run("R8");
    chk(!err, "R8", "err cleared by valid start", err, 0);
  endtask

  task automatic t_busy_ignore();
    setcfg(4, 1, 'h100, 2, 1, 'h140, 2, 1, 'h1C0, 2, 2, ONES, ONES);
    apply_ref();
    launch();
    repeat (3) @(negedge clk);
    setcfg(9, 0, 0, 1, 0, 0, 1, 0, 'h1E0, 1, 1, ONES, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_len = 16'd4;
    finish("R9", 4);
  endtask

  task automatic t_stall();
    stall_en = 1'b1;
    setcfg(6, 1, 'h0A, 2, 3, 'h2F8, -8, 2, 'h3A0, 4, 3, ONES, ONES);
    run("R11");
    setcfg(4, 4, 0, 16, 0, 'h77, 1, 0, 'h3F0, 1, 2, ONES, ONES);
    run("R11");
    stall_en = 1'b0;
  endtask

  initial begin
    for (int w = 0; w < 64; w++)
      for (int k = 0; k < 16; k++) begin
        mem[w][8*k +: 8] = 8'((w*16 + k) * 37 + 11 + w);
        sh[w*16 + k] = 8'((w*16 + k) * 37 + 11 + w);
      end
    t_reset();
    t_plain_copy();
    t_wide_words();
    t_reverse();
    t_funcs();
    t_mul_trunc();
    t_mask();
    t_unaligned();
    t_len0();
    t_error();
    t_busy_ignore();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule